// File: doc/BRIEF.md
# Latched serial-to-parallel shift register

This block converts a serial bit stream into a parallel word with a two-stage structure. A chain of shift stages accepts one bit on every rising edge of a shift clock input. A separate storage register copies the whole chain on every rising edge of a storage clock input. Because the parallel outputs come from the storage register, they change only when the user commits a word, never while bits are still moving.

The last shift stage drives a serial cascade output. Several instances can therefore be chained into a longer register that shares its shift and storage clocks. An active-low clear empties the shift stages at once and leaves the committed word alone. An active-low output enable decides whether the parallel word is driven. A per-bit drive-enable vector takes the place of tri-state pins.

The whole block runs on one system clock. The shift and storage clock inputs are ordinary signals that are synchronised and edge-detected inside the block. The serial data input passes through a delay of the same depth, so it is sampled at the moment of the external shift edge.

Top module: `serial_latch_shifter`

## Requirements
- R1: A detected rising edge of the shift clock input loads the serial data bit into stage 0 and moves every stage i (i >= 1) to the previous value of stage i-1.
- R2: The cascade output always equals the highest shift stage (stage WIDTH-1). After a shift it shows the value stage WIDTH-2 held before that shift.
- R3: A detected rising edge of the storage clock input copies all shift stages into the storage register in one cycle.
- R4: When shift and storage edges are detected in the same cycle, the storage register takes the shift contents from before that shift.
- R5: While clearN is low, all shift stages and the cascade output are 0 with no clock edge required. The storage register keeps its value.
- R6: A storage edge that follows a clear loads all zeros into the storage register.
- R7: With outEnN low, parOut equals the storage register and parDriveEn is all ones. With outEnN high, parDriveEn is all zeros and parOut reads as all zeros.
- R8: outEnN has no effect on the cascade output or on the contents of either register.
- R9: Each shift clock input and each storage clock input passes through a SYNC_STAGES-flop synchroniser. Each external rising edge causes exactly one action, however long the input stays high.
- R10: The active-low system reset rstN sets both the shift register and the storage register to zero.
- R11: parOut bit i comes from shift stage i. Two chained instances act as one register of twice the width, with the first bit shifted in ending in the top stage of the second instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset for both registers |
| serialIn | input | 1 | Serial data bit |
| shiftClkIn | input | 1 | Shift clock, asynchronous level; rising edge shifts |
| storeClkIn | input | 1 | Storage clock, asynchronous level; rising edge commits |
| clearN | input | 1 | Asynchronous active-low clear of the shift stages only |
| outEnN | input | 1 | Active-low parallel output enable |
| parOut | output | WIDTH | Committed parallel word, zero while disabled |
| parDriveEn | output | WIDTH | Per-bit drive enable, all ones when driven |
| cascadeOut | output | 1 | Top shift stage, for chaining |

## Verification
On every cycle the assertions check several behaviours:
- The shift step and its bit ordering.
- The storage capture of the pre-edge shift contents, including when both clocks coincide.
- That the storage register holds without a storage pulse.
- The zeroed shift stages while the clear is held.
- The output gating.
- The single-cycle width of each internal strobe.

Only the bench scenarios can show the end-to-end paths:
- The latency from an external clock level to a changed port.
- That a long-held clock input acts once.
- The zero load after a clear.
- That the enable leaves the cascade path alone.
- That two chained instances behave as one wide register.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
  // Strobes passed from the control side to the datapath.
  typedef struct packed {
    logic shiftPulse;  // one-cycle shift request
    logic storePulse;  // one-cycle commit request
    logic shiftBit;    // serial bit aligned with shiftPulse
  } strobes_t;
endpackage

// File: rtl/s2p_control.sv
module s2p_control
  import s2p_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serialIn,
  input  logic     shiftClkIn,
  input  logic     storeClkIn,
  output strobes_t strobes
);
  localparam int NUM_CLKS = 2;
  localparam int TOP = SYNC_STAGES - 1;

  logic [NUM_CLKS-1:0] rawClk;
  logic [NUM_CLKS-1:0] edgePulse;
  logic [TOP:0]        dataDelay;

  assign rawClk = {storeClkIn, shiftClkIn};

  // One synchroniser and rising-edge detector per clock input.
  for (genvar c = 0; c < NUM_CLKS; c++) begin : g_sync
    logic [TOP:0] chain;
    logic         prevLevel;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain     <= '0;
        prevLevel <= 1'b0;
      end else begin
        chain     <= {chain[TOP-1:0], rawClk[c]};
        prevLevel <= chain[TOP];
      end
    end
    assign edgePulse[c] = chain[TOP] & ~prevLevel;
  end

  // The data bit is delayed by the same depth, so it is sampled at the external edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataDelay <= '0;
    else       dataDelay <= {dataDelay[TOP-1:0], serialIn};
  end

  always_comb begin
    strobes.shiftPulse = edgePulse[0];
    strobes.storePulse = edgePulse[1];
    strobes.shiftBit   = dataDelay[TOP];
  end
endmodule

// File: rtl/s2p_datapath.sv
module s2p_datapath
  import s2p_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearN,
  input  logic             outEnN,
  input  strobes_t         strobes,
  output logic [WIDTH-1:0] shiftQ,
  output logic [WIDTH-1:0] storeQ,
  output logic [WIDTH-1:0] parOut,
  output logic [WIDTH-1:0] parDriveEn,
  output logic             cascadeOut
);
  localparam int LAST = WIDTH - 1;

  logic shiftRstN;
  assign shiftRstN = rstN & clearN;

  // Shift stages: cleared by the system reset or by the clear.
  always_ff @(posedge clk or negedge shiftRstN) begin
    if (!shiftRstN)              shiftQ <= '0;
    else if (strobes.shiftPulse) shiftQ <= {shiftQ[LAST-1:0], strobes.shiftBit};
  end

  // Storage: the nonblocking read gives the pre-shift contents when both strobes coincide.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   storeQ <= '0;
    else if (strobes.storePulse) storeQ <= shiftQ;
  end

  assign cascadeOut = shiftQ[LAST];

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign parDriveEn[i] = ~outEnN;
    assign parOut[i]     = parDriveEn[i] & storeQ[i];
  end
endmodule

// File: rtl/serial_latch_shifter.sv
module serial_latch_shifter
  import s2p_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serialIn,
  input  logic             shiftClkIn,
  input  logic             storeClkIn,
  input  logic             clearN,
  input  logic             outEnN,
  output logic [WIDTH-1:0] parOut,
  output logic [WIDTH-1:0] parDriveEn,
  output logic             cascadeOut
);
  strobes_t         strobes;
  logic [WIDTH-1:0] shiftQ;
  logic [WIDTH-1:0] storeQ;

  s2p_control #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .serialIn(serialIn),
    .shiftClkIn(shiftClkIn), .storeClkIn(storeClkIn), .strobes(strobes)
  );

  s2p_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .clearN(clearN), .outEnN(outEnN), .strobes(strobes),
    .shiftQ(shiftQ), .storeQ(storeQ), .parOut(parOut), .parDriveEn(parDriveEn),
    .cascadeOut(cascadeOut)
  );
endmodule

// File: rtl/s2p_checker.sv
module s2p_checker
  import s2p_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             clearN,
  input logic             outEnN,
  input strobes_t         strobes,
  input logic [WIDTH-1:0] shiftQ,
  input logic [WIDTH-1:0] storeQ,
  input logic [WIDTH-1:0] parOut,
  input logic [WIDTH-1:0] parDriveEn,
  input logic             cascadeOut
);
  localparam int LAST = WIDTH - 1;

  assert_shift_step_R1: assert property (@(posedge clk) disable iff (!rstN || !clearN)
    strobes.shiftPulse |=> shiftQ == {$past(shiftQ[LAST-1:0]), $past(strobes.shiftBit)});

  assert_cascade_top_R2: assert property (@(posedge clk) disable iff (!rstN)
    cascadeOut == shiftQ[LAST]);

  // Also covers R4: the captured value is the pre-shift contents.
  assert_store_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storePulse |=> storeQ == $past(shiftQ));

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !clearN |-> (shiftQ == '0 && !cascadeOut));

  assert_store_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.storePulse |=> $stable(storeQ));

  assert_disabled_out_R7: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (parDriveEn == '0 && parOut == '0));

  assert_enabled_out_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outEnN |-> (parDriveEn == '1 && parOut == storeQ));

  assert_single_shift_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftPulse |=> !strobes.shiftPulse);

  assert_single_store_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storePulse |=> !strobes.storePulse);
endmodule

bind serial_latch_shifter s2p_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .clearN(clearN), .outEnN(outEnN), .strobes(strobes),
  .shiftQ(shiftQ), .storeQ(storeQ), .parOut(parOut), .parDriveEn(parDriveEn),
  .cascadeOut(cascadeOut)
);

// File: tb/serial_latch_shifter_tb.sv
`timescale 1ns/1ps
module serial_latch_shifter_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN, serialIn, shiftClkIn, storeClkIn, clearN, outEnN;
  logic [W-1:0] parOut, parDriveEn, parOut2, parDriveEn2;
  logic cascadeOut, cascadeOut2;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_latch_shifter #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .shiftClkIn(shiftClkIn),
    .storeClkIn(storeClkIn), .clearN(clearN), .outEnN(outEnN),
    .parOut(parOut), .parDriveEn(parDriveEn), .cascadeOut(cascadeOut));

  // Second instance, chained through the cascade output (R11).
  serial_latch_shifter #(.WIDTH(W)) u_dut2 (
    .clk(clk), .rstN(rstN), .serialIn(cascadeOut), .shiftClkIn(shiftClkIn),
    .storeClkIn(storeClkIn), .clearN(clearN), .outEnN(outEnN),
    .parOut(parOut2), .parDriveEn(parDriveEn2), .cascadeOut(cascadeOut2));

  // Row: {doShift, din, doStore, oeN, expected parOut[7:0], expected cascade}
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h02, 1'b0},  // coincident edges (R4)
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h05, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0},  // disabled (R7)
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h0B, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h0B, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h0B, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h0B, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h0B, 1'b1},  // top stage reaches cascade (R2)
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h0B, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h7E, 1'b0}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Raise the requested clock inputs, hold, drop, and wait for the outputs to settle.
  task automatic pulse(logic doShift, logic din, logic doStore, int holdCycles);
    @(negedge clk);
    serialIn   = din;
    shiftClkIn = doShift;
    storeClkIn = doStore;
    repeat (holdCycles) @(negedge clk);
    shiftClkIn = 1'b0;
    storeClkIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    serialIn = 0; shiftClkIn = 0; storeClkIn = 0; clearN = 1; outEnN = 0;
    doReset();
    check("R10 reset parOut", parOut, 0);
    check("R10 reset cascade", cascadeOut, 0);
    check("R7 reset drive enable", parDriveEn, 8'hFF);

    // Table walk: R1 R2 R3 R4 R7
    for (int k = 0; k < NV; k++) begin
      outEnN = VEC[k][9];
      pulse(VEC[k][12], VEC[k][11], VEC[k][10], 4);
      check($sformatf("R1/R3/R4/R7 row %0d parOut", k), parOut, VEC[k][8:1]);
      check($sformatf("R2 row %0d cascade", k), cascadeOut, VEC[k][0]);
      check($sformatf("R7 row %0d drive enable", k), parDriveEn, {W{~VEC[k][9]}});
    end

    // R5: shift 7E -> FD -> FB, then clear asynchronously.
    pulse(1, 1, 0, 4);
    pulse(1, 1, 0, 4);
    check("R2 cascade before clear", cascadeOut, 1);
    @(negedge clk);
    clearN = 1'b0;
    #1;
    check("R5 async clear cascade", cascadeOut, 0);
    check("R5 clear keeps storage", parOut, 8'h7E);
    repeat (3) @(negedge clk);
    clearN = 1'b1;
    pulse(0, 0, 1, 4);
    check("R6 store after clear", parOut, 8'h00);

    // R9: a long-held shift clock shifts once only.
    pulse(1, 1, 0, 20);
    pulse(0, 0, 1, 4);
    check("R9 long high single shift", parOut, 8'h01);

    // R8: push the bit to the top stage, then toggle the enable.
    for (int k = 0; k < 7; k++) pulse(1, 0, 0, 4);
    check("R11 stage order to cascade", cascadeOut, 1);
    @(negedge clk);
    outEnN = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 disable keeps cascade", cascadeOut, 1);
    check("R7 disabled parOut", parOut, 0);
    outEnN = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 storage unchanged by enable", parOut, 8'h01);
    pulse(0, 0, 1, 4);
    check("R8 shift contents unchanged by enable", parOut, 8'h80);

    // R11: two chained instances shift 16 bits, the first bit being 1.
    doReset();
    pulse(1, 1, 0, 4);
    for (int k = 0; k < 15; k++) pulse(1, 0, 0, 4);
    pulse(0, 0, 1, 4);
    check("R11 chained second word", parOut2, 8'h80);
    check("R11 chained first word", parOut, 8'h00);
    check("R11 chained cascade", cascadeOut2, 1);

    // R10: system reset clears both registers.
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R10 reset clears storage", parOut2, 0);
    check("R10 reset clears shift", cascadeOut2, 0);
    rstN = 1'b1;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule